// File: doc/BRIEF.md
# Rotate and Rotate-Through-Carry Unit

This block is the rotate slice of an integer execution pipeline. Each cycle it may accept one operation on an operand of 8, 16, 32 or 64 bits. The four operations are a plain rotate in either direction and a rotate through the carry flag in either direction. The operation moves the bits of the operand by a count and returns the rotated value along with the new carry and overflow flags. A write enable comes with each of the two flags, so the register file of flags updates only what the operation defines.

The count arrives raw as an 8-bit value. The unit masks it according to the operand size. It then reduces the masked count to an effective count. A rotate through carry treats the carry as one extra bit at the top of the operand, so it rotates over width+1 bits. A plain rotate wraps within the operand width. When the effective count is zero, nothing changes and no flag is written. The overflow flag is written only when the raw count is exactly one. The results are registered, with a latency of one cycle.

Top module: `rot_unit`

## Requirements
- R1: Operand size is encoded on `size_sel` as 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = 64 bit. Only the low 6 bits of `count_i` are used for 64-bit operands. Only the low 5 bits are used for the other sizes. Higher count bits never change the outcome.
- R2: For a rotate through carry, the masked count is taken modulo 9 at 8 bits and modulo 17 at 16 bits. At 32 and 64 bits it is used directly.
- R3: For a plain rotate, the masked count is taken modulo the operand width.
- R4: Operation is encoded on `op_sel` as 0 = rotate left, 1 = rotate right, 2 = rotate left through carry, 3 = rotate right through carry. Each step of a left rotate through carry moves `cf` into bit 0 and the operand MSB into `cf`. Each step of a right rotate through carry moves `cf` into the MSB and bit 0 into `cf`.
- R5: A plain rotate ignores the incoming carry when forming the result. The new carry is bit 0 of the result after a left rotate and the MSB of the result after a right rotate.
- R6: When the effective count is zero, the result equals the operand. In that case `cf_we` and `of_we` stay low, and `cf_o`/`of_o` repeat `cf_i`/`of_i`.
- R7: When `count_i` equals 1, `of_we` is high. For left rotates, `of_o` is the result MSB XOR the new carry. For right rotates, it is the XOR of the two top result bits.
- R8: When `count_i` is not 1, `of_we` is low and `of_o` repeats `of_i`. `cf_we` is high exactly when the effective count is nonzero.
- R9: For 8, 16 and 32-bit operands, result bits at and above the operand width are zero. Operand bits above the width have no effect.
- R10: Outputs appear on the clock edge after the one that samples `in_valid`. `out_valid` then follows `in_valid`. Both write enables are low whenever `out_valid` is low, and an active-low synchronous reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | Operation select (R4 encoding) |
| size_sel | input | 2 | Operand size select (R1 encoding) |
| count_i | input | 8 | Raw rotate count |
| operand_i | input | 64 | Operand, low bits used for narrow sizes |
| cf_i | input | 1 | Incoming carry flag |
| of_i | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Registered result valid |
| result_o | output | 64 | Rotated value, zero above the width |
| cf_o | output | 1 | New carry flag |
| of_o | output | 1 | New overflow flag |
| cf_we | output | 1 | Carry flag write enable |
| of_we | output | 1 | Overflow flag write enable |

## Verification
The unit has no state apart from its output register. A wrong count reduction, a wrong barrel stage or a wrong flag selection therefore shows at the ports on the very next cycle after the offending operation, and it does not linger. Because each result is a single registered stage, any corruption surfaces in the one vector that caused it. This makes it important to drive every size, operation and count, including counts beyond the mask and the modulo wrap points, against an independent bit-by-bit model.

// File: rtl/rot_pkg.sv
// Shared encodings and widths for the rotate unit.
// Assumes operand sizes are powers of two from 8 bits upward.
package rot_pkg;
    typedef enum logic [1:0] {
        OP_ROT_L   = 2'd0,
        OP_ROT_R   = 2'd1,
        OP_RCARY_L = 2'd2,
        OP_RCARY_R = 2'd3
    } rot_op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } rot_size_e;

    // Width of an effective rotate amount: must hold the widest span (65).
    localparam int AMT_W = 7;
endpackage

// File: rtl/rot_count_reduce.sv
// Masks the raw count by operand size and reduces it to the effective count.
// Assumes CNT_W >= 6; the result is always below the rotation span.
module rot_count_reduce
    import rot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] raw,
    input  logic [1:0]       size,
    input  logic             thru_carry,
    output logic [AMT_W-1:0] eff
);
    logic [4:0] m5;
    logic [5:0] m6;
    logic [4:0] r9;
    logic [4:0] r17;

    assign m5 = raw[4:0];
    assign m6 = raw[5:0];

    // Modulo 9 and 17 of a 5-bit value by bounded subtraction.
    always_comb begin
        if (m5 >= 5'd27)      r9 = m5 - 5'd27;
        else if (m5 >= 5'd18) r9 = m5 - 5'd18;
        else if (m5 >= 5'd9)  r9 = m5 - 5'd9;
        else                  r9 = m5;
        r17 = (m5 >= 5'd17) ? m5 - 5'd17 : m5;
    end

    // Pick the reduction that matches size and operation kind.
    always_comb begin
        case (size)
            SZ_8:    eff = thru_carry ? AMT_W'(r9)  : AMT_W'(m5[2:0]);
            SZ_16:   eff = thru_carry ? AMT_W'(r17) : AMT_W'(m5[3:0]);
            SZ_32:   eff = AMT_W'(m5);
            default: eff = AMT_W'(m6);
        endcase
    end
endmodule

// File: rtl/rot_barrel.sv
// Logarithmic left rotator over N bits.
// Assumes amt < N; each stage rotates by a power of two reduced modulo N.
module rot_barrel
    import rot_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [N-1:0]     dout
);
    logic [N-1:0] stg [AMT_W+1];

    assign stg[0] = din;

    for (genvar k = 0; k < AMT_W; k++) begin : g_stage
        localparam int SH = (1 << k) % N;
        logic [2*N-1:0] dbl;
        // One stage: conditionally rotate left by SH.
        assign dbl        = {stg[k], stg[k]} << SH;
        assign stg[k+1]   = amt[k] ? dbl[2*N-1:N] : stg[k];
    end

    assign dout = stg[AMT_W];
endmodule

// File: rtl/rot_lane.sv
// One operand-size lane: plain rotate over W bits and carry rotate over W+1.
// Assumes amt is already reduced for the selected kind; right rotates are
// turned into the complementary left rotate.
module rot_lane
    import rot_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]     opnd,
    input  logic             cin,
    input  logic [AMT_W-1:0] amt,
    input  logic             thru,
    input  logic             right,
    output logic [W-1:0]     res,
    output logic             cout,
    output logic             msb,
    output logic             msb2
);
    localparam int NP = W;
    localparam int NC = W + 1;

    logic [AMT_W-1:0] amt_p;
    logic [AMT_W-1:0] amt_c;
    logic [NP-1:0]    res_p;
    logic [NC-1:0]    res_c;

    // Convert a right amount into the equivalent left amount per span.
    always_comb begin
        amt_p = (right && amt != '0) ? AMT_W'(NP) - amt : amt;
        amt_c = (right && amt != '0) ? AMT_W'(NC) - amt : amt;
    end

    rot_barrel #(.N(NP)) u_plain (.din(opnd),        .amt(amt_p), .dout(res_p));
    rot_barrel #(.N(NC)) u_carry (.din({cin, opnd}), .amt(amt_c), .dout(res_c));

    // Split the carry span back into flag and value, or take plain carry.
    always_comb begin
        res  = thru ? res_c[W-1:0] : res_p;
        cout = thru ? res_c[W] : (right ? res_p[W-1] : res_p[0]);
        msb  = res[W-1];
        msb2 = res[W-2];
    end
endmodule

// File: rtl/rot_unit.sv
// Rotate execution unit: four size lanes, count reduction, flag rules and
// one output register stage. Assumes DATA_W = 64 with lanes 8..DATA_W.
module rot_unit
    import rot_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [1:0]        size_sel,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              cf_i,
    input  logic              of_i,
    output logic              out_valid,
    output logic [DATA_W-1:0] result_o,
    output logic              cf_o,
    output logic              of_o,
    output logic              cf_we,
    output logic              of_we
);
    localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;

    logic              thru;
    logic              right;
    logic [AMT_W-1:0]  eff;
    logic [DATA_W-1:0] lane_res  [NUM_SIZES];
    logic              lane_cout [NUM_SIZES];
    logic              lane_msb  [NUM_SIZES];
    logic              lane_msb2 [NUM_SIZES];
    logic [DATA_W-1:0] res_n;
    logic              cf_n, of_n, cfwe_n, ofwe_n, new_cf;

    assign thru  = op_sel[1];
    assign right = op_sel[0];

    rot_count_reduce #(.CNT_W(CNT_W)) u_cnt (
        .raw(count_i), .size(size_sel), .thru_carry(thru), .eff(eff)
    );

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
        localparam int W = 8 << g;
        logic [W-1:0] res_w;
        rot_lane #(.W(W)) u_lane (
            .opnd(operand_i[W-1:0]), .cin(cf_i), .amt(eff), .thru(thru),
            .right(right), .res(res_w), .cout(lane_cout[g]),
            .msb(lane_msb[g]), .msb2(lane_msb2[g])
        );
        assign lane_res[g] = DATA_W'(res_w);
    end

    // Select the active lane and apply the flag write rules.
    always_comb begin
        res_n  = lane_res[size_sel];
        new_cf = lane_cout[size_sel];
        cfwe_n = (eff != '0);
        ofwe_n = (count_i == CNT_W'(1));
        cf_n   = cfwe_n ? new_cf : cf_i;
        if (!ofwe_n)    of_n = of_i;
        else if (right) of_n = lane_msb[size_sel] ^ lane_msb2[size_sel];
        else            of_n = lane_msb[size_sel] ^ new_cf;
    end

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result_o  <= '0;
            cf_o      <= 1'b0;
            of_o      <= 1'b0;
            cf_we     <= 1'b0;
            of_we     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            cf_we     <= in_valid & cfwe_n;
            of_we     <= in_valid & ofwe_n;
            if (in_valid) begin
                result_o <= res_n;
                cf_o     <= cf_n;
                of_o     <= of_n;
            end
        end
    end
endmodule

// File: rtl/rot_unit_chk.sv
// Port-level temporal checks for rot_unit, attached by bind.
module rot_unit_chk #(
    parameter int DATA_W = 64,
    parameter int CNT_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        op_sel,
    input logic [1:0]        size_sel,
    input logic [CNT_W-1:0]  count_i,
    input logic              cf_i,
    input logic              of_i,
    input logic              out_valid,
    input logic [DATA_W-1:0] result_o,
    input logic              cf_o,
    input logic              of_o,
    input logic              cf_we,
    input logic              of_we
);
    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R10
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!cf_we && !of_we));
    // R8
    of_only_count1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && count_i != CNT_W'(1)) |=> (!of_we && of_o == $past(of_i)));
    // R6
    cf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cf_we || cf_o == $past(cf_i)));
    // R5
    rol_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 2'd0) |=> (!cf_we || cf_o == result_o[0]));
    // R9
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_sel == 2'd0) |=> (result_o[DATA_W-1:8] == '0));
endmodule

bind rot_unit rot_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .size_sel(size_sel), .count_i(count_i), .cf_i(cf_i), .of_i(of_i),
    .out_valid(out_valid), .result_o(result_o), .cf_o(cf_o), .of_o(of_o),
    .cf_we(cf_we), .of_we(of_we)
);

// File: tb/rot_unit_tb.sv
`timescale 1ns/1ps
module rot_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic [7:0]  count_i = '0;
    logic [63:0] operand_i = '0;
    logic        cf_i = 1'b0;
    logic        of_i = 1'b0;
    logic        out_valid;
    logic [63:0] result_o;
    logic        cf_o, of_o, cf_we, of_we;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Expected values for the vector applied one cycle earlier.
    bit          have_exp = 1'b0;
    logic [63:0] e_res;
    logic        e_cf, e_of, e_cfwe, e_ofwe;
    string       e_tag;

    always #2.5 clk = ~clk;

    rot_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .size_sel(size_sel), .count_i(count_i), .operand_i(operand_i),
        .cf_i(cf_i), .of_i(of_i), .out_valid(out_valid), .result_o(result_o),
        .cf_o(cf_o), .of_o(of_o), .cf_we(cf_we), .of_we(of_we)
    );

    // Bit-serial behavioural reference.
    task automatic ref_model(input int op, input int sz, input int cnt,
                             input logic [63:0] opnd, input logic cf, input logic of_in,
                             output logic [63:0] r, output logic c, output logic o,
                             output logic cwe, output logic owe, output string tag);
        int w = 8 << sz;
        logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
        int m = (sz == 3) ? (cnt & 63) : (cnt & 31);
        int t;
        logic b;
        if (op >= 2) t = (sz == 0) ? m % 9 : (sz == 1) ? m % 17 : m;
        else         t = m % w;
        r = opnd & mask;
        c = cf;
        for (int i = 0; i < t; i++) begin
            case (op)
                0: begin b = r[w-1]; r = ((r << 1) | 64'(b)) & mask; end
                1: begin b = r[0];   r = (r >> 1) | (64'(b) << (w-1)); end
                2: begin b = r[w-1]; r = ((r << 1) | 64'(c)) & mask; c = b; end
                default: begin b = r[0]; r = (r >> 1) | (64'(c) << (w-1)); c = b; end
            endcase
        end
        cwe = (t != 0);
        if (t == 0)       c = cf;
        else if (op == 0) c = r[0];
        else if (op == 1) c = r[w-1];
        owe = (cnt == 1);
        if (!owe)               o = of_in;
        else if (op % 2 == 0)   o = r[w-1] ^ c;
        else                    o = r[w-1] ^ r[w-2];
        tag = (op >= 2) ? "R2 R4" : "R3 R5";
        tag = {tag, owe ? " R7" : " R8"};
        if (t == 0) tag = {tag, " R6"};
        if (sz < 3) tag = {tag, " R9"};
        if (cnt > 31) tag = {tag, " R1"};
    endtask

    // Compare the outputs against the pending expectation, if any.
    task automatic check_prev();
        if (have_exp) begin
            vectors++;
            if (out_valid !== 1'b1 || result_o !== e_res || cf_o !== e_cf ||
                of_o !== e_of || cf_we !== e_cfwe || of_we !== e_ofwe) begin
                errors++;
                $display("FAIL %s R10: got v=%b r=%h cf=%b of=%b we=%b%b exp v=1 r=%h cf=%b of=%b we=%b%b",
                         e_tag, out_valid, result_o, cf_o, of_o, cf_we, of_we,
                         e_res, e_cf, e_of, e_cfwe, e_ofwe);
            end
        end
    endtask

    // One cycle: check last vector, drive the next one, compute expectation.
    task automatic step(input int op, input int sz, input int cnt,
                        input logic [63:0] opnd, input logic cf, input logic of_in);
        check_prev();
        in_valid  = 1'b1;
        op_sel    = 2'(op);
        size_sel  = 2'(sz);
        count_i   = 8'(cnt);
        operand_i = opnd;
        cf_i      = cf;
        of_i      = of_in;
        ref_model(op, sz, cnt, opnd, cf, of_in, e_res, e_cf, e_of, e_cfwe, e_ofwe, e_tag);
        have_exp = 1'b1;
        @(negedge clk);
    endtask

    // Idle cycle: out_valid and both write enables must be low afterwards (R10).
    task automatic idle_check();
        check_prev();
        have_exp = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0 || cf_we !== 1'b0 || of_we !== 1'b0) begin
            errors++;
            $display("FAIL R10 idle: got v=%b we=%b%b exp v=0 we=00",
                     out_valid, cf_we, of_we);
        end
    endtask

    initial begin
        logic [63:0] pat = 64'h9E37_79B9_7F4A_7C15;
        repeat (3) @(negedge clk);
        vectors++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: got v=%b exp v=0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        for (int op = 0; op < 4; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int cnt = 0; cnt < 72; cnt++) begin
                    pat = {pat[62:0], pat[63] ^ pat[62] ^ pat[60] ^ pat[59]};
                    step(op, sz, cnt, pat, cnt[0] ^ pat[5], pat[9]);
                end
        for (int op = 0; op < 4; op++)
            for (int sz = 0; sz < 4; sz++) begin
                step(op, sz, 1,   64'h8000_0000_0000_0001, 1'b1, 1'b0);
                step(op, sz, 1,   64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b1);
                step(op, sz, 129, 64'h0123_4567_89AB_CDEF, 1'b1, 1'b1);
                step(op, sz, 255, 64'h00C0_FFEE_1234_5680, 1'b0, 1'b0);
                step(op, sz, 224, 64'h7FFF_0000_FFFF_0001, 1'b1, 1'b0);
            end
        idle_check();
        step(2, 0, 9, 64'h0000_0000_0000_00A5, 1'b1, 1'b1);
        step(3, 1, 17, 64'hFFFF_0000_0000_8001, 1'b0, 1'b1);
        idle_check();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a miscompare and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: got timeout exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule